// File: doc/BRIEF.md
# Single-Precision Floating-Point Adder with Selectable Rounding

A purely combinational binary32 adder/subtractor. Two 32-bit operands enter together with an operation select and a rounding-mode code. In the same cycle the block returns the rounded sum or difference and the five standard exception flags. It is meant to sit inside a larger arithmetic datapath that registers the result where its timing requires.

Each input falls into one of four classes, held in an enumerated type. **NAN_IN** means at least one operand is a NaN. **INVALID** means infinities of opposite effective sign are added. **INF_IN** means exactly one infinity is present, or both infinities agree in sign. **NUMERIC** covers all other inputs, where both operands are finite. Only the NUMERIC class uses the datapath: it aligns the operands with guard, round and sticky bits, adds or subtracts the magnitudes, renormalises, rounds and detects overflow. The other classes select a fixed encoding.

There are no states or transitions, because the block has no clock. The class is decoded fresh from the inputs on every evaluation.

Top module: `fp_addsub_rm`

## Requirements
- R1: `rnd_mode` selects the rounding: 0 is nearest-even, 1 is nearest with ties away from zero, 2 rounds toward +infinity, 3 rounds toward -infinity and 4 rounds toward zero. Codes 5 to 7 behave as 0. Example: 0x4C000000 + 0x40000000 gives 0x4C000001 under codes 1 and 2 and 0x4C000000 otherwise. Example: 0x4C000001 + 0x40000000 gives 0x4C000002 under codes 0, 1 and 2 and 0x4C000001 under codes 3 and 4.
- R2: Directed modes act on the sign of the true result. For 0xCC000001 + 0xC0000000, code 2 gives 0xCC000001 and code 3 gives 0xCC000002.
- R3: `op_sub` = 1 computes a − b. This is identical to adding b with its sign bit (bit 31) inverted.
- R4: If either operand is a NaN (exponent bits 30:23 all ones, fraction nonzero), the result is 0x7FC00000. The invalid flag is raised only when a NaN operand is signalling, meaning fraction bit 22 is 0.
- R5: Adding infinities of opposite effective sign gives 0x7FC00000 with the invalid flag set. Infinity combined with a finite value returns that infinity and raises no flag.
- R6: When operands of opposite effective sign cancel exactly, the result is +0 (0x00000000) in every mode except code 3, which gives -0 (0x80000000). When both operands are zeros of the same sign, that sign is kept.
- R7: On overflow the overflow and inexact flags are set. Codes 0 and 1 return infinity of the result's sign. Code 4 returns the largest finite value of that sign (0x7F7FFFFF or 0xFF7FFFFF). Code 2 returns +infinity for a positive result and 0xFF7FFFFF for a negative one. Code 3 is the mirror image of code 2.
- R8: The underflow and divide-by-zero flags are always 0. A result that is subnormal or zero is always exact.
- R9: For finite operands, the result equals the exact sum rounded per R1. The inexact flag is set exactly when the rounded value differs from the exact sum.
- R10: The inexact flag stays clear in two cases. First, when both exponent fields are equal, there is no overflow and the low 8 fraction bits of both operands are zero. Second, when the exponents differ by less than 8, the low 8 fraction bits are zero and the result is finite and below the largest finite magnitude.
- R11: Subnormal operands are handled as exact values, including sums that carry into the smallest normal number. Example: 0x007FFFFF + 0x00000001 = 0x00800000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_a | input | 32 | First operand, binary32 |
| opnd_b | input | 32 | Second operand, binary32 |
| op_sub | input | 1 | 0: a + b, 1: a − b |
| rnd_mode | input | 3 | Rounding-mode code (see R1) |
| result | output | 32 | Rounded result, binary32 |
| flag_nv | output | 1 | Invalid operation |
| flag_dz | output | 1 | Divide by zero (always 0) |
| flag_of | output | 1 | Overflow |
| flag_uf | output | 1 | Underflow (always 0) |
| flag_nx | output | 1 | Inexact |

## Verification
The bench builds the block with its default 8-bit exponent and 23-bit fraction. With these widths, the exact sum of any two operands fits in a 300-bit integer counted in units of the smallest subnormal. This lets the reference model add exactly and then round, without copying the alignment datapath. The defaults also bring the fixed tie vectors near 2^25 within reach, together with the overflow edge at 0x7F7FFFFF, the subnormal-to-normal carry, and random operands drawn both over the whole encoding space and with nearby exponents so that rounding occurs often.

// File: rtl/fpadd_pkg.sv
package fpadd_pkg;

    typedef enum logic [2:0] {
        RM_NEAR_EVEN = 3'd0,
        RM_NEAR_AWAY = 3'd1,
        RM_UP        = 3'd2,
        RM_DOWN      = 3'd3,
        RM_ZERO      = 3'd4
    } rmode_e;

    typedef enum logic [1:0] {
        NAN_IN  = 2'd0,
        INVALID = 2'd1,
        INF_IN  = 2'd2,
        NUMERIC = 2'd3
    } kind_e;

    function automatic rmode_e decode_rm(input logic [2:0] code);
        case (code)
            3'd1:    return RM_NEAR_AWAY;
            3'd2:    return RM_UP;
            3'd3:    return RM_DOWN;
            3'd4:    return RM_ZERO;
            default: return RM_NEAR_EVEN;
        endcase
    endfunction

endpackage

// File: rtl/fpadd_unpack.sv
module fpadd_unpack #(
    parameter int EXP_W = 8,
    parameter int MAN_W = 23
) (
    input  logic [EXP_W+MAN_W:0] word,
    output logic                 sign,
    output logic [EXP_W-1:0]     exp_eff,
    output logic [MAN_W:0]       sig,
    output logic                 is_inf,
    output logic                 is_nan,
    output logic                 is_snan
);
    localparam int W = EXP_W + MAN_W + 1;

    logic [EXP_W-1:0] e_fld;
    logic [MAN_W-1:0] f_fld;
    logic             e_ones;
    logic             e_zero;

    assign sign    = word[W-1];
    assign e_fld   = word[W-2:MAN_W];
    assign f_fld   = word[MAN_W-1:0];
    assign e_ones  = &e_fld;
    assign e_zero  = ~|e_fld;
    // subnormals share the scale of the smallest normal exponent
    assign exp_eff = e_zero ? {{(EXP_W-1){1'b0}}, 1'b1} : e_fld;
    assign sig     = {~e_zero, f_fld};
    assign is_inf  = e_ones & ~|f_fld;
    assign is_nan  = e_ones & |f_fld;
    assign is_snan = is_nan & ~f_fld[MAN_W-1];

endmodule

// File: rtl/fpadd_align.sv
module fpadd_align #(
    parameter int EXP_W = 8,
    parameter int MAN_W = 23
) (
    input  logic [MAN_W:0]   big_sig,
    input  logic [EXP_W-1:0] big_exp,
    input  logic [MAN_W:0]   small_sig,
    input  logic [EXP_W-1:0] small_exp,
    input  logic             do_sub,
    output logic [MAN_W+4:0] sum
);
    // three extra low bits: guard, round, sticky
    localparam int SW = MAN_W + 4;

    logic [EXP_W-1:0] diff;
    logic [SW-1:0]    big_x;
    logic [SW-1:0]    small_x;
    logic [SW-1:0]    shifted;
    logic [SW-1:0]    aligned;
    logic             lost;

    assign diff    = big_exp - small_exp;
    assign big_x   = {big_sig, 3'b000};
    assign small_x = {small_sig, 3'b000};

    always_comb begin
        if (32'(diff) >= SW) begin
            shifted = '0;
            lost    = |small_x;
        end else begin
            shifted = small_x >> diff;
            lost    = |(small_x & ~({SW{1'b1}} << diff));
        end
        aligned = shifted | {{(SW-1){1'b0}}, lost};
        if (do_sub) begin
            sum = {1'b0, big_x} - {1'b0, aligned};
        end else begin
            sum = {1'b0, big_x} + {1'b0, aligned};
        end
    end

    // R3: operand ordering by magnitude means subtraction never borrows
    always_comb begin
        if (do_sub) begin
            no_borrow_chk: assert (!sum[SW] && (big_exp >= small_exp));
        end
    end

endmodule

// File: rtl/fpadd_round.sv
module fpadd_round
    import fpadd_pkg::*;
#(
    parameter int EXP_W = 8,
    parameter int MAN_W = 23
) (
    input  logic [MAN_W+4:0]       sum,
    input  logic [EXP_W-1:0]       exp_in,
    input  logic                   sign,
    input  rmode_e                 rm,
    output logic [EXP_W+MAN_W-1:0] mag,
    output logic                   ovf,
    output logic                   inexact,
    output logic                   is_zero
);
    localparam int SW   = MAN_W + 4;
    localparam int EW   = EXP_W + 2;
    localparam int MAXE = (1 << EXP_W) - 1;

    logic [SW-1:0]  m1;
    logic [SW-1:0]  m2;
    logic [EW-1:0]  e1;
    logic [EW-1:0]  e2;
    logic [EW-1:0]  e3;
    logic [MAN_W+1:0] mant;
    logic [MAN_W:0] mant_n;
    logic           rb;
    logic           st;
    logic           lsb;
    logic           up;
    logic           to_inf;
    int             lz;
    int             sh;

    // renormalise: right by one on carry, else left but not below exponent 1
    always_comb begin
        if (sum[SW]) begin
            m1 = sum[SW:1] | {{(SW-1){1'b0}}, sum[0]};
            e1 = EW'(exp_in) + EW'(1);
        end else begin
            m1 = sum[SW-1:0];
            e1 = EW'(exp_in);
        end
        lz = SW;
        for (int i = 0; i < SW; i++) begin
            if (m1[i]) lz = SW - 1 - i;
        end
        sh = (lz < int'(e1) - 1) ? lz : int'(e1) - 1;
        m2 = m1 << sh;
        e2 = e1 - EW'(sh);
    end

    always_comb begin
        rb      = m2[2];
        st      = |m2[1:0];
        lsb     = m2[3];
        is_zero = ~|m2;
        unique case (rm)
            RM_NEAR_EVEN: up = rb & (st | lsb);
            RM_NEAR_AWAY: up = rb;
            RM_UP:        up = ~sign & (rb | st);
            RM_DOWN:      up = sign & (rb | st);
            RM_ZERO:      up = 1'b0;
            default:      up = 1'b0;
        endcase
        mant = {1'b0, m2[SW-1:3]} + {{(MAN_W+1){1'b0}}, up};
        if (mant[MAN_W+1]) begin
            mant_n = mant[MAN_W+1:1];
            e3     = e2 + EW'(1);
        end else begin
            mant_n = mant[MAN_W:0];
            e3     = e2;
        end
        ovf    = e3 >= EW'(MAXE);
        to_inf = (rm == RM_NEAR_EVEN) || (rm == RM_NEAR_AWAY) ||
                 ((rm == RM_UP) && !sign) || ((rm == RM_DOWN) && sign);
        inexact = rb | st | ovf;
        if (ovf) begin
            mag = to_inf ? {{EXP_W{1'b1}}, {MAN_W{1'b0}}}
                         : {{(EXP_W-1){1'b1}}, 1'b0, {MAN_W{1'b1}}};
        end else if (mant_n[MAN_W]) begin
            mag = {e3[EXP_W-1:0], mant_n[MAN_W-1:0]};
        end else begin
            mag = {{EXP_W{1'b0}}, mant_n[MAN_W-1:0]};
        end
    end

    // R8: a subnormal or zero sum carries no rounding error
    always_comb begin
        if (!ovf && (mag[EXP_W+MAN_W-1:MAN_W] == '0)) begin
            subnormal_exact_chk: assert (!(rb | st));
        end
    end

endmodule

// File: rtl/fp_addsub_rm.sv
module fp_addsub_rm
    import fpadd_pkg::*;
#(
    parameter int EXP_W = 8,
    parameter int MAN_W = 23
) (
    input  logic [EXP_W+MAN_W:0] opnd_a,
    input  logic [EXP_W+MAN_W:0] opnd_b,
    input  logic                 op_sub,
    input  logic [2:0]           rnd_mode,
    output logic [EXP_W+MAN_W:0] result,
    output logic                 flag_nv,
    output logic                 flag_dz,
    output logic                 flag_of,
    output logic                 flag_uf,
    output logic                 flag_nx
);
    localparam int W  = EXP_W + MAN_W + 1;
    localparam int SW = MAN_W + 4;
    localparam logic [W-1:0] QNAN    = {1'b0, {EXP_W{1'b1}}, 1'b1, {(MAN_W-1){1'b0}}};
    localparam logic [W-1:0] POS_INF = {1'b0, {EXP_W{1'b1}}, {MAN_W{1'b0}}};
    localparam logic [W-1:0] NEG_MAX = {1'b1, {(EXP_W-1){1'b1}}, 1'b0, {MAN_W{1'b1}}};

    logic             a_sign, b_sign, b_sign_eff;
    logic [EXP_W-1:0] a_exp, b_exp;
    logic [MAN_W:0]   a_sig, b_sig;
    logic             a_inf, b_inf, a_nan, b_nan, a_snan, b_snan;
    logic             a_larger, do_sub, big_sign, sign_out;
    logic [SW:0]      sum;
    logic [W-2:0]     rnd_mag;
    logic             rnd_ovf, rnd_nx, rnd_zero;
    rmode_e           rm;
    kind_e            kind;

    fpadd_unpack #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_unpack_a (
        .word(opnd_a), .sign(a_sign), .exp_eff(a_exp), .sig(a_sig),
        .is_inf(a_inf), .is_nan(a_nan), .is_snan(a_snan)
    );

    fpadd_unpack #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_unpack_b (
        .word(opnd_b), .sign(b_sign), .exp_eff(b_exp), .sig(b_sig),
        .is_inf(b_inf), .is_nan(b_nan), .is_snan(b_snan)
    );

    assign rm         = decode_rm(rnd_mode);
    assign b_sign_eff = b_sign ^ op_sub;
    assign do_sub     = a_sign ^ b_sign_eff;
    assign a_larger   = opnd_a[W-2:0] >= opnd_b[W-2:0];
    assign big_sign   = a_larger ? a_sign : b_sign_eff;

    fpadd_align #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_align (
        .big_sig  (a_larger ? a_sig : b_sig),
        .big_exp  (a_larger ? a_exp : b_exp),
        .small_sig(a_larger ? b_sig : a_sig),
        .small_exp(a_larger ? b_exp : a_exp),
        .do_sub   (do_sub),
        .sum      (sum)
    );

    fpadd_round #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_round (
        .sum    (sum),
        .exp_in (a_larger ? a_exp : b_exp),
        .sign   (big_sign),
        .rm     (rm),
        .mag    (rnd_mag),
        .ovf    (rnd_ovf),
        .inexact(rnd_nx),
        .is_zero(rnd_zero)
    );

    // operand class decode
    always_comb begin
        if (a_nan || b_nan)                kind = NAN_IN;
        else if (a_inf && b_inf && do_sub) kind = INVALID;
        else if (a_inf || b_inf)           kind = INF_IN;
        else                               kind = NUMERIC;
    end

    // outputs per class
    always_comb begin
        flag_dz  = 1'b0;
        flag_uf  = 1'b0;
        flag_nv  = 1'b0;
        flag_of  = 1'b0;
        flag_nx  = 1'b0;
        sign_out = big_sign;
        unique case (kind)
            NAN_IN: begin
                result  = QNAN;
                flag_nv = a_snan | b_snan;
            end
            INVALID: begin
                result  = QNAN;
                flag_nv = 1'b1;
            end
            INF_IN: begin
                result = {a_inf ? a_sign : b_sign_eff, POS_INF[W-2:0]};
            end
            NUMERIC: begin
                if (rnd_zero && do_sub) sign_out = (rm == RM_DOWN);
                result  = {sign_out, rnd_mag};
                flag_of = rnd_ovf;
                flag_nx = rnd_nx;
            end
            default: result = QNAN;
        endcase
    end

    // R4
    always_comb begin
        if (a_nan || b_nan) begin
            nan_prop_chk: assert ((&result[W-2:MAN_W]) && (|result[MAN_W-1:0]));
        end
    end

    // R4
    always_comb begin
        if (a_snan || b_snan) begin
            snan_nv_chk: assert (flag_nv);
        end
    end

    // R7
    always_comb begin
        if (rm == RM_UP && flag_of) begin
            up_ovf_chk: assert (result == POS_INF || result == NEG_MAX);
        end
    end

    // R7
    always_comb begin
        if (rm == RM_ZERO && flag_of) begin
            zero_ovf_chk: assert (!(&result[W-2:MAN_W]));
        end
    end

    // R10
    always_comb begin
        if (kind == NUMERIC && opnd_a[W-2:MAN_W] == opnd_b[W-2:MAN_W] && !flag_of &&
            opnd_a[7:0] == 8'h00 && opnd_b[7:0] == 8'h00) begin
            eq_exp_exact_chk: assert (!flag_nx);
        end
    end

endmodule

// File: tb/test_fp_addsub_rm.sv
module test_fp_addsub_rm;
    localparam int CLK_PERIOD = 10;
    typedef logic [299:0] wide_t;

    logic        clk = 1'b0;
    logic [31:0] opnd_a = '0, opnd_b = '0;
    logic        op_sub = 1'b0;
    logic [2:0]  rnd_mode = '0;
    logic [31:0] result;
    logic        flag_nv, flag_dz, flag_of, flag_uf, flag_nx;
    int          checks = 0;
    int          fails  = 0;
    bit          done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fp_addsub_rm i_fp_addsub_rm (
        .opnd_a(opnd_a), .opnd_b(opnd_b), .op_sub(op_sub), .rnd_mode(rnd_mode),
        .result(result), .flag_nv(flag_nv), .flag_dz(flag_dz), .flag_of(flag_of),
        .flag_uf(flag_uf), .flag_nx(flag_nx)
    );

    // exact-then-round reference; returns {result, nv, dz, of, uf, nx}
    function automatic logic [36:0] ref_add(input logic [31:0] a, input logic [31:0] b,
                                            input logic sub, input logic [2:0] code);
        logic sa, sb, s, up, inx, toinf;
        logic [7:0] ea, eb;
        logic [22:0] fa, fb;
        wide_t ma, mb, mag, keep, rem, half;
        int mode, p, sh, ef;
        sa = a[31]; sb = b[31] ^ sub;
        ea = a[30:23]; eb = b[30:23]; fa = a[22:0]; fb = b[22:0];
        mode = (code <= 3'd4) ? int'(code) : 0;
        if ((ea == 8'hFF && fa != 0) || (eb == 8'hFF && fb != 0))
            return {32'h7FC00000, ((ea == 8'hFF && fa != 0 && !fa[22]) ||
                                   (eb == 8'hFF && fb != 0 && !fb[22])), 4'b0};
        if (ea == 8'hFF && eb == 8'hFF && sa != sb) return {32'h7FC00000, 5'b10000};
        if (ea == 8'hFF) return {sa, 8'hFF, 23'h0, 5'b0};
        if (eb == 8'hFF) return {sb, 8'hFF, 23'h0, 5'b0};
        ma = wide_t'({ea != 0, fa}) << ((ea == 0) ? 0 : int'(ea) - 1);
        mb = wide_t'({eb != 0, fb}) << ((eb == 0) ? 0 : int'(eb) - 1);
        if (sa == sb) begin mag = ma + mb; s = sa; end
        else if (ma >= mb) begin mag = ma - mb; s = sa; end
        else begin mag = mb - ma; s = sb; end
        if (mag == 0) begin
            s = (sa == sb) ? sa : (mode == 3);
            return {s, 31'h0, 5'b0};
        end
        p = 0;
        for (int i = 0; i < 300; i++) if (mag[i]) p = i;
        if (p <= 23) return {s, mag[30:0], 5'b0};
        sh   = p - 23;
        keep = mag >> sh;
        rem  = mag & ((wide_t'(1) << sh) - 1);
        half = wide_t'(1) << (sh - 1);
        inx  = (rem != 0);
        case (mode)
            0: up = (rem > half) || (rem == half && keep[0]);
            1: up = (rem >= half);
            2: up = inx && !s;
            3: up = inx && s;
            default: up = 1'b0;
        endcase
        keep = keep + wide_t'(up);
        if (keep[24]) begin keep = keep >> 1; sh++; end
        ef = sh + 1;
        if (ef >= 255) begin
            toinf = (mode <= 1) || (mode == 2 && !s) || (mode == 3 && s);
            return {s, toinf ? {8'hFF, 23'h0} : {8'hFE, 23'h7FFFFF}, 5'b00101};
        end
        return {s, 8'(ef), keep[22:0], 4'b0, inx};
    endfunction

    task automatic drive(input logic [31:0] a, input logic [31:0] b, input logic s,
                         input logic [2:0] m);
        @(posedge clk);
        #1;
        opnd_a = a; opnd_b = b; op_sub = s; rnd_mode = m;
        @(negedge clk);
    endtask

    task automatic compare(input string tag, input logic [36:0] exp_v);
        logic [36:0] act;
        act = {result, flag_nv, flag_dz, flag_of, flag_uf, flag_nx};
        checks++;
        if (act !== exp_v) begin
            fails++;
            $display("FAIL %s a=%h b=%h sub=%b rm=%0d actual=%h expected=%h",
                     tag, opnd_a, opnd_b, op_sub, rnd_mode, act, exp_v);
        end
    endtask

    task automatic run_ref(input string tag, input logic [31:0] a, input logic [31:0] b,
                           input logic s, input logic [2:0] m);
        drive(a, b, s, m);
        compare(tag, ref_add(a, b, s, m));
    endtask

    task automatic run_fix(input string tag, input logic [31:0] a, input logic [31:0] b,
                           input logic s, input logic [2:0] m, input logic [31:0] r,
                           input logic [4:0] f);
        drive(a, b, s, m);
        compare(tag, {r, f});
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            fails++;
            $display("FAIL R9 watchdog actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] ra, rb;
        // idle state: +0 + +0 (R6)
        @(negedge clk);
        compare("R6 idle", {32'h0, 5'b0});

        // R1 tie vectors, positive
        run_fix("R1", 32'h4C000000, 32'h40000000, 0, 3'd0, 32'h4C000000, 5'b00001);
        run_fix("R1", 32'h4C000000, 32'h40000000, 0, 3'd1, 32'h4C000001, 5'b00001);
        run_fix("R1", 32'h4C000000, 32'h40000000, 0, 3'd2, 32'h4C000001, 5'b00001);
        run_fix("R1", 32'h4C000000, 32'h40000000, 0, 3'd3, 32'h4C000000, 5'b00001);
        run_fix("R1", 32'h4C000000, 32'h40000000, 0, 3'd4, 32'h4C000000, 5'b00001);
        run_fix("R1", 32'h4C000001, 32'h40000000, 0, 3'd0, 32'h4C000002, 5'b00001);
        run_fix("R1", 32'h4C000001, 32'h40000000, 0, 3'd1, 32'h4C000002, 5'b00001);
        run_fix("R1", 32'h4C000001, 32'h40000000, 0, 3'd2, 32'h4C000002, 5'b00001);
        run_fix("R1", 32'h4C000001, 32'h40000000, 0, 3'd3, 32'h4C000001, 5'b00001);
        run_fix("R1", 32'h4C000001, 32'h40000000, 0, 3'd4, 32'h4C000001, 5'b00001);
        for (int m = 5; m < 8; m++)
            run_fix("R1 spare code", 32'h4C000001, 32'h40000000, 0, 3'(m), 32'h4C000002, 5'b00001);
        // R2 negative ties
        run_fix("R2", 32'hCC000000, 32'hC0000000, 0, 3'd0, 32'hCC000000, 5'b00001);
        run_fix("R2", 32'hCC000000, 32'hC0000000, 0, 3'd1, 32'hCC000001, 5'b00001);
        run_fix("R2", 32'hCC000000, 32'hC0000000, 0, 3'd2, 32'hCC000000, 5'b00001);
        run_fix("R2", 32'hCC000000, 32'hC0000000, 0, 3'd3, 32'hCC000001, 5'b00001);
        run_fix("R2", 32'hCC000000, 32'hC0000000, 0, 3'd4, 32'hCC000000, 5'b00001);
        run_fix("R2", 32'hCC000001, 32'hC0000000, 0, 3'd0, 32'hCC000002, 5'b00001);
        run_fix("R2", 32'hCC000001, 32'hC0000000, 0, 3'd1, 32'hCC000002, 5'b00001);
        run_fix("R2", 32'hCC000001, 32'hC0000000, 0, 3'd2, 32'hCC000001, 5'b00001);
        run_fix("R2", 32'hCC000001, 32'hC0000000, 0, 3'd3, 32'hCC000002, 5'b00001);
        run_fix("R2", 32'hCC000001, 32'hC0000000, 0, 3'd4, 32'hCC000001, 5'b00001);
        // R3 subtraction
        run_fix("R3", 32'h4C000000, 32'hC0000000, 1, 3'd2, 32'h4C000001, 5'b00001);
        run_fix("R3", 32'h40400000, 32'h3F800000, 1, 3'd0, 32'h40000000, 5'b00000);
        // R4 NaNs
        run_fix("R4 quiet", 32'h7FC00001, 32'h3F800000, 0, 3'd0, 32'h7FC00000, 5'b00000);
        run_fix("R4 signalling", 32'h3F800000, 32'hFF800001, 0, 3'd0, 32'h7FC00000, 5'b10000);
        // R5 infinities
        run_fix("R5 inf-inf", 32'h7F800000, 32'hFF800000, 0, 3'd0, 32'h7FC00000, 5'b10000);
        run_fix("R5 inf-inf sub", 32'h7F800000, 32'h7F800000, 1, 3'd3, 32'h7FC00000, 5'b10000);
        run_fix("R5 inf+x", 32'h3F800000, 32'hFF800000, 0, 3'd2, 32'hFF800000, 5'b00000);
        // R6 zeros
        for (int m = 0; m < 5; m++)
            run_fix("R6 cancel", 32'h3F800000, 32'hBF800000, 0, 3'(m),
                    (m == 3) ? 32'h80000000 : 32'h00000000, 5'b00000);
        run_fix("R6 neg zeros", 32'h80000000, 32'h80000000, 0, 3'd2, 32'h80000000, 5'b00000);
        run_fix("R6 x-x", 32'h12345678, 32'h12345678, 1, 3'd3, 32'h80000000, 5'b00000);
        // R7 overflow
        run_fix("R7", 32'h7F7FFFFF, 32'h7F7FFFFF, 0, 3'd0, 32'h7F800000, 5'b00101);
        run_fix("R7", 32'h7F7FFFFF, 32'h7F7FFFFF, 0, 3'd4, 32'h7F7FFFFF, 5'b00101);
        run_fix("R7", 32'h7F7FFFFF, 32'h7F7FFFFF, 0, 3'd3, 32'h7F7FFFFF, 5'b00101);
        run_fix("R7", 32'hFF7FFFFF, 32'hFF7FFFFF, 0, 3'd2, 32'hFF7FFFFF, 5'b00101);
        run_fix("R7", 32'hFF7FFFFF, 32'hFF7FFFFF, 0, 3'd3, 32'hFF800000, 5'b00101);
        run_fix("R7", 32'hFF7FFFFF, 32'h7F7FFFFF, 1, 3'd1, 32'hFF800000, 5'b00101);
        // R8 / R11 subnormals
        run_fix("R11", 32'h00000001, 32'h00000001, 0, 3'd0, 32'h00000002, 5'b00000);
        run_fix("R11", 32'h007FFFFF, 32'h00000001, 0, 3'd0, 32'h00800000, 5'b00000);
        run_fix("R8", 32'h00800000, 32'h007FFFFF, 1, 3'd2, 32'h00000001, 5'b00000);
        run_fix("R8", 32'h00800001, 32'h80800000, 0, 3'd4, 32'h00000001, 5'b00000);
        // R10 exact cases
        run_fix("R10", 32'h3F800100, 32'h3FC00000, 0, 3'd0, 32'h40200080, 5'b00000);
        run_ref("R10", 32'h41000000, 32'h3F800000, 0, 3'd4);
        run_ref("R10", 32'h40A00200, 32'hBF800100, 0, 3'd2);
        // R9 random, whole encoding space
        for (int i = 0; i < 1500; i++) begin
            ra = $urandom; rb = $urandom;
            run_ref("R9 random", ra, rb, 1'($urandom), 3'($urandom));
        end
        // R9 random, nearby exponents
        for (int i = 0; i < 1500; i++) begin
            ra = $urandom;
            rb = $urandom;
            rb[30:23] = ra[30:23] - 8'($urandom % 30);
            run_ref("R9 near", ra, rb, 1'($urandom), 3'($urandom % 5));
        end
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

endmodule